// File: doc/BRIEF.md
# Interval Timer with Standby-Wake Settling

This block is an 8-bit up-counter that advances on a one-cycle tick taken from a free-running prescaler. A 3-bit select code picks the tap. With the enable bit set, the counter runs and wraps from 0xFF to 0x00. In interval mode each wrap sets a sticky interrupt flag. In watchdog mode each wrap gives a one-cycle reset pulse instead.

The same counter also times clock settling after a low-power standby. Standby can only be entered while the timer is disabled. A standby request made while the timer is enabled has no effect. In standby the chip-wide clock enable is low. A wake (NMI) event clears the counter and starts it on the tap selected before standby. The first wrap after the wake marks the clock as stable. The block then returns to normal operation and raises the clock enable again.

The controller has three states:
- ST_RUN: normal operation, clocks enabled.
- ST_STANDBY: asleep, waiting for a wake event.
- ST_SETTLE: counting one full overflow period after the wake.

It has three transitions:
- Standby entry: ST_RUN to ST_STANDBY, on a standby request while disabled.
- Wake: ST_STANDBY to ST_SETTLE, on a wake event.
- Settle done: ST_SETTLE to ST_RUN, on the first overflow.

Top module: `wake_interval_timer`

## Requirements
- R1: The 8-bit counter increments by one on each tick while it is running. From 0xFF it wraps to 0x00, and this wrap is the overflow. The counter runs in ST_RUN with enable 1, and always in ST_SETTLE.
- R2: Select code k (0..7) gives one tick every 2^(k+1) clock cycles. A continuously running counter therefore overflows exactly 256 x 2^(k+1) cycles apart (code 0 gives 512 cycles).
- R3: In interval mode (mode bit 0) with enable 1, an overflow sets irq_flag in the following cycle. The flag stays set until a control write with ctl_flag_wr = 0 clears it. A set arriving in the same cycle as a clear wins.
- R4: In watchdog mode (mode bit 1) with enable 1, an overflow makes wdt_rst_pulse high for exactly one cycle and leaves irq_flag unchanged.
- R5: A counter write loads cnt_wdata, which is readable on cnt_rdata in the next cycle. If a tick falls in the same cycle, the write takes priority.
- R6: In ST_RUN with enable 0, the counter holds its value.
- R7: A standby request is ignored while enable is 1: clk_en stays 1 and the counter keeps counting. With enable 0, clk_en goes low in the next cycle and stays low through standby and settling.
- R8: A wake event in standby clears the counter to 0x00 and enters ST_SETTLE. Settling uses the select code held before standby. Control writes are ignored outside ST_RUN.
- R9: The first overflow in ST_SETTLE returns the block to ST_RUN and raises clk_en. This overflow sets no irq_flag and gives no reset pulse.
- R10: After reset the block has counter 0x00, clk_en 1, irq_flag 0, wdt_rst_pulse 0, enable 0, and is in ST_RUN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_en | input | 1 | Enable bit written by the control write |
| ctl_mode | input | 1 | Mode bit: 0 interval, 1 watchdog |
| ctl_cks | input | 3 | Tick select code |
| ctl_flag_wr | input | 1 | Flag bit written; 0 clears irq_flag |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter load value |
| cnt_rdata | output | 8 | Current counter value |
| stby_req | input | 1 | Standby entry request |
| wake_nmi | input | 1 | Wake event from standby |
| irq_flag | output | 1 | Sticky interval interrupt flag |
| wdt_rst_pulse | output | 1 | One-cycle watchdog reset pulse |
| clk_en | output | 1 | Chip-wide clock enable |

## Verification
A wrong tick tap or a wrong counter step shows up as an overflow period that is off. The error is visible at the first or second interrupt, within a few hundred cycles.

A controller stuck in the wrong state shows on clk_en one cycle after the standby request or wake event. A lost latched select code shows as a settling time outside its window, about a thousand cycles after the wake.

A wrong flag or pulse route shows as an unexpected event on the wrong output. That event is seen on the cycle after the overflow that caused it.

// File: rtl/wit_pkg.sv
package wit_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_STANDBY = 2'd1,
        ST_SETTLE  = 2'd2
    } wit_state_e;

    typedef enum logic {
        MD_INTERVAL = 1'b0,
        MD_WATCHDOG = 1'b1
    } wit_mode_e;
endpackage

// File: rtl/wit_prescaler.sv
module wit_prescaler #(
    parameter int CKS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CKS_W-1:0] sel,
    output logic             tick
);
    localparam int NTAP = 1 << CKS_W;
    localparam int PW   = NTAP;

    logic [PW-1:0]   presc;
    logic [NTAP-1:0] taps;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) presc <= '0;
        else        presc <= presc + 1'b1;
    end

    // Tap k fires when the low k+1 bits are all ones: divide by 2^(k+1).
    for (genvar k = 0; k < NTAP; k++) begin : g_tap
        assign taps[k] = &presc[k:0];
    end

    assign tick = taps[sel];

    // R2: the fastest tap is divide-by-2, so ticks never come back to back
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/wit_counter.sv
module wit_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             clr,
    input  logic             we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt <= '0;
        else if (clr)             cnt <= '0;
        else if (we)              cnt <= wdata;
        else if (run && tick)     cnt <= cnt + 1'b1;
    end

    assign ovf = run && tick && !we && !clr && (cnt == TOP);

    // R5: a write lands on the next cycle, whatever the tick does
    a_r5_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr) |=> (cnt == $past(wdata)));

    // R6: no run, no write, no clear: value holds
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !we && !clr) |=> $stable(cnt));

    // R1: one tick while running moves the count by exactly one (mod 256)
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !we && !clr) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    // R8: the wake clear always leaves zero
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/wit_ctrl.sv
module wit_ctrl
    import wit_pkg::*;
#(
    parameter int CKS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             ctl_en,
    input  logic             ctl_mode,
    input  logic [CKS_W-1:0] ctl_cks,
    input  logic             ctl_flag_wr,
    input  logic             stby_req,
    input  logic             wake_nmi,
    input  logic             ovf,
    output logic             run,
    output logic [CKS_W-1:0] cks_sel,
    output logic             wake_clr,
    output logic             irq_flag,
    output logic             rst_pulse,
    output logic             clk_en
);
    wit_state_e       state_q, state_d;
    logic             en_q;
    wit_mode_e        mode_q;
    logic [CKS_W-1:0] cks_q;
    logic             go_standby;
    logic             ctl_ok;
    logic             flag_set;
    logic             pulse_d;

    assign go_standby = (state_q == ST_RUN) && stby_req && !en_q;
    assign ctl_ok     = ctl_we && (state_q == ST_RUN) && !go_standby;
    assign flag_set   = ovf && (state_q == ST_RUN) && (mode_q == MD_INTERVAL);
    assign pulse_d    = ovf && (state_q == ST_RUN) && (mode_q == MD_WATCHDOG);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (go_standby) state_d = ST_STANDBY;
            ST_STANDBY: if (wake_nmi)   state_d = ST_SETTLE;
            ST_SETTLE:  if (ovf)        state_d = ST_RUN;
            default:                    state_d = ST_RUN;
        endcase
    end

    // Per-state outputs
    always_comb begin
        run      = 1'b0;
        wake_clr = 1'b0;
        clk_en   = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                run    = en_q;
                clk_en = 1'b1;
            end
            ST_STANDBY: wake_clr = wake_nmi;
            ST_SETTLE:  run      = 1'b1;
            default:    clk_en   = 1'b1;
        endcase
    end

    // Control fields, flag and pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            mode_q    <= MD_INTERVAL;
            cks_q     <= '0;
            irq_flag  <= 1'b0;
            rst_pulse <= 1'b0;
        end else begin
            if (ctl_ok) begin
                en_q   <= ctl_en;
                mode_q <= wit_mode_e'(ctl_mode);
                cks_q  <= ctl_cks;
            end
            if (flag_set)                   irq_flag <= 1'b1;
            else if (ctl_ok && !ctl_flag_wr) irq_flag <= 1'b0;
            rst_pulse <= pulse_d;
        end
    end

    assign cks_sel = cks_q;

    // R7: an enabled timer stays in normal operation
    a_r7_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && en_q) |=> (state_q == ST_RUN));

    // R7: clocks only drop after a standby request
    a_r7_clk_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en) |-> $past(stby_req));

    // R9: clocks only come back after a counter overflow
    a_r9_clk_return: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en) |-> $past(ovf));

    // R9: settling never raises the flag or a reset pulse
    a_r9_settle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && !irq_flag) |=> (!irq_flag && !rst_pulse));

    // R3: flag is sticky until an explicit clear
    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !(ctl_we && !ctl_flag_wr)) |=> irq_flag);

    // R4: reset pulse is one cycle wide
    a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |=> !rst_pulse);
endmodule

// File: rtl/wake_interval_timer.sv
module wake_interval_timer #(
    parameter int CNT_W = 8,
    parameter int CKS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             ctl_en,
    input  logic             ctl_mode,
    input  logic [CKS_W-1:0] ctl_cks,
    input  logic             ctl_flag_wr,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt_rdata,
    input  logic             stby_req,
    input  logic             wake_nmi,
    output logic             irq_flag,
    output logic             wdt_rst_pulse,
    output logic             clk_en
);
    logic             tick;
    logic             run;
    logic             wake_clr;
    logic             ovf;
    logic [CKS_W-1:0] cks_sel;

    wit_prescaler #(.CKS_W(CKS_W)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .sel  (cks_sel),
        .tick (tick)
    );

    wit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick),
        .clr  (wake_clr),
        .we   (cnt_we),
        .wdata(cnt_wdata),
        .cnt  (cnt_rdata),
        .ovf  (ovf)
    );

    wit_ctrl #(.CKS_W(CKS_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_we     (ctl_we),
        .ctl_en     (ctl_en),
        .ctl_mode   (ctl_mode),
        .ctl_cks    (ctl_cks),
        .ctl_flag_wr(ctl_flag_wr),
        .stby_req   (stby_req),
        .wake_nmi   (wake_nmi),
        .ovf        (ovf),
        .run        (run),
        .cks_sel    (cks_sel),
        .wake_clr   (wake_clr),
        .irq_flag   (irq_flag),
        .rst_pulse  (wdt_rst_pulse),
        .clk_en     (clk_en)
    );
endmodule

// File: tb/wake_interval_timer_test.sv
`timescale 1ns/1ps
module wake_interval_timer_test;
    localparam int EV_IRQ  = 0;
    localparam int EV_RST  = 1;
    localparam int EV_WAKE = 2;

    typedef struct {
        int    kind;
        int    lo;
        int    hi;
        string req;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0, ctl_en = 1'b0, ctl_mode = 1'b0, ctl_flag_wr = 1'b1;
    logic [2:0] ctl_cks = '0;
    logic       cnt_we = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic [7:0] cnt_rdata;
    logic       stby_req = 1'b0, wake_nmi = 1'b0;
    logic       irq_flag, wdt_rst_pulse, clk_en;

    int tests = 0, fails = 0;
    int cyc = 0;
    int n_irq = 0, n_rst = 0, n_wake = 0;
    int last_irq_cyc = 0, last_irq_cnt = 0;
    int rst_hi = 0;
    logic p_irq = 1'b0, p_rst = 1'b0, p_clk = 1'b1;
    exp_item_t expq[$];

    wake_interval_timer uut (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_en(ctl_en), .ctl_mode(ctl_mode),
        .ctl_cks(ctl_cks), .ctl_flag_wr(ctl_flag_wr),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
        .stby_req(stby_req), .wake_nmi(wake_nmi),
        .irq_flag(irq_flag), .wdt_rst_pulse(wdt_rst_pulse), .clk_en(clk_en)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic expect_ev(input int kind, input int lo, input int hi, input string req);
        exp_item_t it;
        it.kind = kind; it.lo = lo; it.hi = hi; it.req = req;
        expq.push_back(it);
    endtask

    task automatic seen_ev(input int kind);
        exp_item_t it;
        if (expq.size() == 0) begin
            chk(1'b0, "unexpected event", kind, -1);
        end else begin
            it = expq.pop_front();
            chk(it.kind == kind, it.req, kind, it.kind);
            chk(cyc >= it.lo && cyc <= it.hi, it.req, cyc, it.lo);
        end
    endtask

    // Monitor: pops expected events as outputs rise
    always @(negedge clk) begin
        if (rst_n) begin
            if (wdt_rst_pulse) rst_hi++;
            if (irq_flag && !p_irq) begin
                last_irq_cyc = cyc;
                last_irq_cnt = int'(cnt_rdata);
                seen_ev(EV_IRQ);
                n_irq++;
            end
            if (wdt_rst_pulse && !p_rst) begin
                seen_ev(EV_RST);
                n_rst++;
            end
            if (clk_en && !p_clk) begin
                seen_ev(EV_WAKE);
                n_wake++;
            end
        end
        p_irq = irq_flag;
        p_rst = wdt_rst_pulse;
        p_clk = clk_en;
    end

    // Driver tasks: called at a negedge, the next posedge acts
    task automatic ctl_write(input logic en, input logic md, input logic [2:0] cks, input logic fw);
        ctl_we = 1'b1; ctl_en = en; ctl_mode = md; ctl_cks = cks; ctl_flag_wr = fw;
        @(negedge clk);
        ctl_we = 1'b0; ctl_flag_wr = 1'b1;
    endtask

    task automatic cnt_write(input logic [7:0] v);
        cnt_we = 1'b1; cnt_wdata = v;
        @(negedge clk);
        cnt_we = 1'b0;
    endtask

    task automatic pulse_stby();
        stby_req = 1'b1;
        @(negedge clk);
        stby_req = 1'b0;
    endtask

    task automatic pulse_wake();
        wake_nmi = 1'b1;
        @(negedge clk);
        wake_nmi = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int t1;
        int c0;
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(cnt_rdata == 8'h00, "R10 counter", int'(cnt_rdata), 0);
        chk(clk_en == 1'b1, "R10 clk_en", int'(clk_en), 1);
        chk(irq_flag == 1'b0, "R10 irq_flag", int'(irq_flag), 0);
        chk(wdt_rst_pulse == 1'b0, "R10 pulse", int'(wdt_rst_pulse), 0);

        // R5: writes in consecutive cycles, both tick phases, code 0
        ctl_write(1'b1, 1'b0, 3'd0, 1'b1);
        cnt_write(8'h37);
        chk(cnt_rdata == 8'h37, "R5 load a", int'(cnt_rdata), 'h37);
        cnt_write(8'h5A);
        chk(cnt_rdata == 8'h5A, "R5 load b", int'(cnt_rdata), 'h5A);

        // R1/R3: interval overflow from 0xF0
        cnt_write(8'hF0);
        expect_ev(EV_IRQ, cyc, cyc + 40, "R3 first interrupt");
        wait (n_irq == 1);
        t1 = last_irq_cyc;
        chk(last_irq_cnt == 0, "R1 wrap to zero", last_irq_cnt, 0);
        ctl_write(1'b1, 1'b0, 3'd0, 1'b0);
        chk(irq_flag == 1'b0, "R3 clear", int'(irq_flag), 0);
        // R2: next overflow exactly 512 cycles later
        expect_ev(EV_IRQ, t1 + 512, t1 + 512, "R2 period code 0");
        wait (n_irq == 2);
        repeat (20) @(negedge clk);
        chk(irq_flag == 1'b1, "R3 sticky", int'(irq_flag), 1);

        // R4: watchdog mode pulse
        ctl_write(1'b1, 1'b1, 3'd0, 1'b0);
        rst_hi = 0;
        cnt_write(8'hFE);
        expect_ev(EV_RST, cyc, cyc + 6, "R4 reset pulse");
        wait (n_rst == 1);
        repeat (5) @(negedge clk);
        chk(rst_hi == 1, "R4 pulse width", rst_hi, 1);
        chk(irq_flag == 1'b0, "R4 no interrupt", int'(irq_flag), 0);

        // R6: disabled counter holds
        ctl_write(1'b0, 1'b0, 3'd0, 1'b1);
        v = int'(cnt_rdata);
        repeat (40) @(negedge clk);
        chk(int'(cnt_rdata) == v, "R6 hold", int'(cnt_rdata), v);

        // R7: standby refused while enabled
        ctl_write(1'b1, 1'b0, 3'd0, 1'b1);
        pulse_stby();
        repeat (3) @(negedge clk);
        chk(clk_en == 1'b1, "R7 refused clk_en", int'(clk_en), 1);
        v = int'(cnt_rdata);
        repeat (10) @(negedge clk);
        chk(int'(cnt_rdata) != v, "R7 still counting", int'(cnt_rdata), v);

        // R7/R8: standby with code 1 latched, then a code-3 write ignored
        ctl_write(1'b0, 1'b0, 3'd1, 1'b0);
        cnt_write(8'h80);
        pulse_stby();
        chk(clk_en == 1'b0, "R7 standby clk_en", int'(clk_en), 0);
        ctl_write(1'b0, 1'b0, 3'd3, 1'b1);
        repeat (5) @(negedge clk);
        chk(clk_en == 1'b0, "R7 clk_en stays low", int'(clk_en), 0);
        pulse_wake();
        c0 = cyc;
        chk(cnt_rdata == 8'h00, "R8 wake clears", int'(cnt_rdata), 0);
        expect_ev(EV_WAKE, c0 + 1021, c0 + 1024, "R8 settle on latched code 1");
        wait (n_wake == 1);
        chk(irq_flag == 1'b0, "R9 no interrupt on settle", int'(irq_flag), 0);

        // R9: second standby with code 0
        ctl_write(1'b0, 1'b0, 3'd0, 1'b1);
        pulse_stby();
        pulse_wake();
        c0 = cyc;
        expect_ev(EV_WAKE, c0 + 511, c0 + 512, "R9 settle code 0");
        wait (n_wake == 2);
        chk(clk_en == 1'b1, "R9 clocks back", int'(clk_en), 1);

        repeat (10) @(negedge clk);
        chk(expq.size() == 0, "all expected events seen", expq.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule